// File: doc/BRIEF.md
# Runtime parameter register bank

This block holds a set of runtime parameters that software sets over a simple 32-bit register port, and presents each parameter to neighbouring logic as a parallel output. Each parameter has its own width of 1 to 64 bits. Whenever software changes a parameter, a one-clock update strobe for that parameter goes high. Logic that consumes the parameter can reload its settings on that strobe instead of watching the value.

A parameter wider than the bus takes two consecutive word addresses. The lower word is first captured in a shadow register. The visible output changes only when the upper word arrives, so consumers never see a half-written value, and the strobe pulses once per complete update. The bank also holds a format selector that tells downstream logic which of NUM_FMT image protocols is active. Protocols are numbered from zero, and the selector output is just wide enough to hold NUM_FMT-1.

Software can read back every committed value through a registered read port.

Top module: `param_reg_bank`

## Requirements
- R1: After reset, every parameter output, the format selector and `rd_data` are zero, and no update strobe is high until software writes.
- R2: A parameter of 32 bits or fewer lives at word address 2*i, where i is its index. A write there loads its low PW[i] bits into the output on the next clock edge, and `par_upd_o[i]` is high during the cycle after that edge.
- R3: A parameter wider than 32 bits takes address 2*i for bits 31:0 and address 2*i+1 for the bits above. A write to the lower address changes neither the output nor the strobe.
- R4: A parameter output only changes on an edge that also raises its strobe. Each committing write gives a strobe exactly one cycle long.
- R5: Output slot i is 64 bits wide. Bits at and above PW[i] are always zero, and bits of a written word beyond the parameter width are dropped.
- R6: The format selector lives at address 2*NP and is ceil(log2(NUM_FMT)) bits wide. Writes of values below NUM_FMT commit and pulse `fmt_upd_o` for one cycle. Writes of larger values are ignored.
- R7: A write to an unmapped address changes no output and raises no strobe, and a read from one returns zero. Unmapped addresses are the odd address of a single-word parameter and every address above 2*NP.
- R8: `rd_data` shows the committed value, zero-extended, one cycle after `rd_en`. It never shows a pending shadow word, and it holds its value while `rd_en` is low.
- R9: The shadow of a wide parameter keeps the last lower word written, including across commits. Writing only the upper word therefore commits with the retained lower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | 32 | Read result, valid the cycle after rd_en |
| par_data_o | output | NP*64 | Parameter outputs, slot i at bits 64*i+63 : 64*i |
| par_upd_o | output | NP | One-cycle update strobe per parameter |
| fmt_id_o | output | FW | Active protocol number |
| fmt_upd_o | output | 1 | One-cycle strobe on a format change |

## Verification
A table of writes covers three parameter shapes: a narrow 12-bit one, a full 64-bit one and a 40-bit one whose upper word is partly unused. The narrow case shows truncation. The 40-bit case separates a correct top-word mask from one that leaks high bits. Repeated lower-word writes, and upper-only commits, tell a shadow that keeps its last word apart from one that is cleared or that commits early. Format writes at the last legal number and one past it expose an off-by-one range guard. Reads of shadowed, unmapped and masked words show whether readback uses committed state.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int BUS_W = 32;
  localparam int MAXW  = 64;
  localparam int SLOTS = (MAXW + BUS_W - 1) / BUS_W;

  function automatic int words_for(input int w);
    return (w + BUS_W - 1) / BUS_W;
  endfunction
endpackage

// File: rtl/prb_decode.sv
module prb_decode #(
  parameter int AW = 4,
  parameter int NP = 3
) (
  input  logic [AW-1:0] addr,
  output logic [AW-2:0] idx,
  output logic          word,
  output logic          is_par,
  output logic          is_fid
);
  // two word slots per parameter, selector right after the last slot
  always_comb begin
    idx    = addr[AW-1:1];
    word   = addr[0];
    is_par = idx < (AW-1)'(NP);
    is_fid = addr == AW'(2 * NP);
  end
endmodule

// File: rtl/prb_param.sv
module prb_param
  import prb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_word,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_word,
  output logic [W-1:0]     q,
  output logic             upd,
  output logic [BUS_W-1:0] rd_val
);
  localparam int NW   = words_for(W);
  localparam int PADW = NW * BUS_W;

  logic [PADW-1:0] qpad;
  assign qpad = PADW'(q);

  generate
    if (NW == 1) begin : g_single
      logic unused_hi;
      assign unused_hi = ^wr_data;

      always_ff @(posedge clk) begin
        if (rst) begin
          q   <= '0;
          upd <= 1'b0;
        end else begin
          upd <= 1'b0;
          if (wr_en && !wr_word) begin
            q   <= wr_data[W-1:0];
            upd <= 1'b1;
          end
        end
      end

      always_comb rd_val = rd_word ? '0 : qpad[BUS_W-1:0];
    end else begin : g_double
      logic [BUS_W-1:0]   shadow;
      logic [2*BUS_W-1:0] full;
      logic               unused_full;

      assign full        = {wr_data, shadow};
      assign unused_full = ^full;

      always_ff @(posedge clk) begin
        if (rst) begin
          q      <= '0;
          upd    <= 1'b0;
          shadow <= '0;
        end else begin
          upd <= 1'b0;
          if (wr_en) begin
            if (!wr_word) begin
              shadow <= wr_data;
            end else begin
              q   <= full[W-1:0];
              upd <= 1'b1;
            end
          end
        end
      end

      always_comb rd_val = rd_word ? qpad[2*BUS_W-1:BUS_W] : qpad[BUS_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/prb_fmt.sv
module prb_fmt
  import prb_pkg::*;
#(
  parameter int NUM_FMT = 5,
  parameter int FW      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [FW-1:0]    fid,
  output logic             upd,
  output logic [BUS_W-1:0] rd_val
);
  logic legal;
  assign legal = wr_data < BUS_W'(NUM_FMT);

  always_ff @(posedge clk) begin
    if (rst) begin
      fid <= '0;
      upd <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (wr_en && legal) begin
        fid <= wr_data[FW-1:0];
        upd <= 1'b1;
      end
    end
  end

  assign rd_val = BUS_W'(fid);
endmodule

// File: rtl/param_reg_bank.sv
module param_reg_bank
  import prb_pkg::*;
#(
  parameter int          NP      = 3,
  parameter int unsigned PW [NP] = '{12, 64, 40},
  parameter int          NUM_FMT = 5,
  parameter int          AW      = 4,
  localparam int         FW      = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic [NP*MAXW-1:0] par_data_o,
  output logic [NP-1:0]     par_upd_o,
  output logic [FW-1:0]     fmt_id_o,
  output logic              fmt_upd_o
);
  logic [AW-2:0] w_idx, r_idx;
  logic          w_word, r_word;
  logic          w_par, r_par, w_fid, r_fid;

  prb_decode #(.AW(AW), .NP(NP)) u_wdec (
    .addr(wr_addr), .idx(w_idx), .word(w_word), .is_par(w_par), .is_fid(w_fid)
  );
  prb_decode #(.AW(AW), .NP(NP)) u_rdec (
    .addr(rd_addr), .idx(r_idx), .word(r_word), .is_par(r_par), .is_fid(r_fid)
  );

  logic [BUS_W-1:0] prv [NP];
  logic [BUS_W-1:0] fmt_rv;

  generate
    for (genvar g = 0; g < NP; g++) begin : g_par
      logic [PW[g]-1:0] q;
      logic             sel;
      assign sel = wr_en && w_par && (w_idx == (AW-1)'(g));

      prb_param #(.W(PW[g])) u_par (
        .clk(clk), .rst(rst), .wr_en(sel), .wr_word(w_word), .wr_data(wr_data),
        .rd_word(r_word), .q(q), .upd(par_upd_o[g]), .rd_val(prv[g])
      );

      assign par_data_o[g*MAXW +: MAXW] = MAXW'(q);
    end
  endgenerate

  prb_fmt #(.NUM_FMT(NUM_FMT), .FW(FW)) u_fmt (
    .clk(clk), .rst(rst), .wr_en(wr_en && w_fid), .wr_data(wr_data),
    .fid(fmt_id_o), .upd(fmt_upd_o), .rd_val(fmt_rv)
  );

  logic [BUS_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (r_fid) rd_next = fmt_rv;
    for (int k = 0; k < NP; k++) begin
      if (r_par && (r_idx == (AW-1)'(k))) rd_next = prv[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/prb_chk.sv
module prb_chk
  import prb_pkg::*;
#(
  parameter int          NP      = 3,
  parameter int unsigned PW [NP] = '{12, 64, 40},
  parameter int          NUM_FMT = 5,
  localparam int         FW      = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               rd_en,
  input logic [BUS_W-1:0]   rd_data,
  input logic [NP*MAXW-1:0] par_data_o,
  input logic [NP-1:0]      par_upd_o,
  input logic [FW-1:0]      fmt_id_o,
  input logic               fmt_upd_o
);
  generate
    for (genvar g = 0; g < NP; g++) begin : g_c
      assert_change_strobed_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(par_data_o[g*MAXW +: MAXW]) |-> par_upd_o[g]);
      if (PW[g] < MAXW) begin : g_hi
        assert_high_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
          par_data_o[g*MAXW + PW[g] +: (MAXW - PW[g])] == '0);
      end
    end
  endgenerate

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (par_upd_o == '0) && !fmt_upd_o);

  assert_fmt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    32'(fmt_id_o) < NUM_FMT);

  assert_fmt_change_strobed_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt_id_o) |-> fmt_upd_o);

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind param_reg_bank prb_chk #(.NP(NP), .PW(PW), .NUM_FMT(NUM_FMT)) u_chk (.*);

// File: tb/sim_param_reg_bank.sv
`timescale 1ns/1ps
module sim_param_reg_bank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [3:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [191:0] par_data_o;
  logic [2:0]   par_upd_o;
  logic [2:0]   fmt_id_o;
  logic         fmt_upd_o;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  param_reg_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .par_data_o(par_data_o),
    .par_upd_o(par_upd_o), .fmt_id_o(fmt_id_o), .fmt_upd_o(fmt_upd_o)
  );

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] d;
    logic [1:0]  sl;
    logic [63:0] ev;
    logic [2:0]  eu;
    logic [2:0]  ef;
    logic        efu;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 32'hABCD_E123, 2'd0, 64'h123,                   3'b001, 3'd0, 1'b0, 4'd5}, // R2 R5
    '{4'd2, 32'h1111_2222, 2'd1, 64'h0,                     3'b000, 3'd0, 1'b0, 4'd3}, // R3
    '{4'd3, 32'h3333_4444, 2'd1, 64'h3333_4444_1111_2222,   3'b010, 3'd0, 1'b0, 4'd3}, // R3
    '{4'd4, 32'hDEAD_BEEF, 2'd2, 64'h0,                     3'b000, 3'd0, 1'b0, 4'd3}, // R3
    '{4'd5, 32'hFFFF_FF5A, 2'd2, 64'h5A_DEAD_BEEF,          3'b100, 3'd0, 1'b0, 4'd5}, // R5
    '{4'd6, 32'h0000_0003, 2'd0, 64'h123,                   3'b000, 3'd3, 1'b1, 4'd6}, // R6
    '{4'd6, 32'h0000_0005, 2'd0, 64'h123,                   3'b000, 3'd3, 1'b0, 4'd6}, // R6
    '{4'd1, 32'hFFFF_FFFF, 2'd0, 64'h123,                   3'b000, 3'd3, 1'b0, 4'd7}, // R7
    '{4'd7, 32'hFFFF_FFFF, 2'd1, 64'h3333_4444_1111_2222,   3'b000, 3'd3, 1'b0, 4'd7}, // R7
    '{4'd3, 32'h0000_0001, 2'd1, 64'h0000_0001_1111_2222,   3'b010, 3'd3, 1'b0, 4'd9}, // R9
    '{4'd2, 32'hAAAA_0000, 2'd1, 64'h0000_0001_1111_2222,   3'b000, 3'd3, 1'b0, 4'd3}, // R3
    '{4'd2, 32'h5555_0000, 2'd1, 64'h0000_0001_1111_2222,   3'b000, 3'd3, 1'b0, 4'd3}, // R3
    '{4'd3, 32'h0000_0007, 2'd1, 64'h0000_0007_5555_0000,   3'b010, 3'd3, 1'b0, 4'd9}, // R9
    '{4'd6, 32'h0000_0004, 2'd0, 64'h123,                   3'b000, 3'd4, 1'b1, 4'd6}, // R6
    '{4'd6, 32'h0000_0000, 2'd0, 64'h123,                   3'b000, 3'd0, 1'b1, 4'd6}  // R6
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 params", {8'h0, par_data_o[191:136]} | par_data_o[63:0] | par_data_o[127:64], 64'h0);
    chk("R1 strobes", {60'h0, par_upd_o, fmt_upd_o}, 64'h0);
    chk("R1 fmt/rd", {29'h0, fmt_id_o, rd_data}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d);
      chk($sformatf("R%0d step %0d value", VEC[i].rq, i), par_data_o[VEC[i].sl*64 +: 64], VEC[i].ev);
      chk($sformatf("R%0d step %0d strobe", VEC[i].rq, i), 64'(par_upd_o), 64'(VEC[i].eu));
      chk($sformatf("R%0d step %0d fmt", VEC[i].rq, i), 64'({fmt_id_o, fmt_upd_o}), 64'({VEC[i].ef, VEC[i].efu}));
      @(negedge clk);
      // R4: strobes last a single cycle
      chk($sformatf("R4 step %0d strobe end", i), 64'({par_upd_o, fmt_upd_o}), 64'h0);
    end

    // R8: readback of committed values
    rd(4'd3, v); chk("R8 read word 3", 64'(v), 64'h7);
    rd(4'd2, v); chk("R8 read word 2", 64'(v), 64'h5555_0000);
    rd(4'd0, v); chk("R8 read word 0", 64'(v), 64'h123);
    rd(4'd5, v); chk("R5 read masked top", 64'(v), 64'h5A);
    rd(4'd7, v); chk("R7 read unmapped 7", 64'(v), 64'h0);
    rd(4'd1, v); chk("R7 read unmapped 1", 64'(v), 64'h0);
    rd(4'd9, v); chk("R7 read unmapped 9", 64'(v), 64'h0);

    // R8: hold while rd_en low
    rd(4'd4, held);
    rd_addr = 4'd0;
    repeat (3) @(negedge clk);
    chk("R8 hold", 64'(rd_data), 64'(held));
    chk("R8 hold value", 64'(held), 64'hDEAD_BEEF);

    // R3 / R8: pending shadow not visible
    wr(4'd2, 32'h0000_9999);
    chk("R3 shadow not output", par_data_o[127:64], 64'h0000_0007_5555_0000);
    rd(4'd2, v); chk("R8 shadow not read", 64'(v), 64'h5555_0000);
    wr(4'd6, 32'h0000_0002);
    rd(4'd6, v); chk("R6 read fmt", 64'(v), 64'h2);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset params", par_data_o[63:0] | par_data_o[127:64] | par_data_o[191:128], 64'h0);
    chk("R1 re-reset outs", {28'h0, par_upd_o, fmt_upd_o, rd_data}, 64'h0);
    chk("R1 re-reset fmt", 64'(fmt_id_o), 64'h0);
    summary();
  end
endmodule